// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-path cache: a direct-mapped array sits next to a small fully associative side store. The side store holds only lines that the array has pushed out. A CPU read is looked up in the array first. If the array misses, the side store is searched next, by full block address. When the side store holds the line, the line swaps places with the line that occupies its array set, and no next-level request is made. When both miss, one block request goes to the next level. The returned line fills the array, and the line it displaces moves into the side store.

The swap breaks the ping-pong effect between two blocks that share an index. After warm-up, such an alternating stream is served entirely from the array and the side store. The side store is searched only after the array misses, so the path to the next level is one cycle longer. Three counters report array hits, side-store hits and next-level requests.

The default array has 16 sets of four 32-bit words. Addresses are 16-bit word addresses: bits [1:0] select the word, bits [5:2] the set and bits [15:6] the tag. The block address is bits [15:2].

Top module: `vcache_top`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and mem_req_valid_o are 0, and all three counters are 0.
- R2: A read that hits the array returns the addressed word with rsp_valid_o one cycle after the lookup cycle, and hit_cnt_o increments.
- R3: The side store is searched only after an array miss. A side-store hit answers without a next-level request and increments vhit_cnt_o.
- R4: On a side-store hit, the hit line moves into the array and the displaced array line takes the freed side-store slot in the same cycle. A later read of the displaced block is therefore a side-store hit.
- R5: When both the array and the side store miss, exactly one next-level request is issued, carrying the block address (address bits [15:2]). The word returned on mem_rsp_data_i (word w at bits [32w+31:32w]) is delivered to the CPU and fills the array.
- R6: Only lines evicted from a valid array set enter the side store. A fill into an empty set leaves the side store unchanged.
- R7: The side store takes an empty slot first. When it is full, it replaces its least recently inserted or hit entry, with NV entries (4 or 8).
- R8: An alternating stream to two blocks with the same index, once both have been fetched, is served with no next-level request.
- R9: Each accepted read increments exactly one of hit_cnt_o, vhit_cnt_o or miss_cnt_o.
- R10: mem_req_valid_o stays high with a stable address until mem_req_ready_i is seen, and drops after the handshake.
- R11: Only one read is in flight at a time. req_ready_o is low in the cycle after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | CPU read request valid |
| req_ready_o | output | 1 | Block can accept a read |
| req_addr_i | input | 16 | CPU word address |
| rsp_valid_o | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data_o | output | 32 | Read data word |
| mem_req_valid_o | output | 1 | Next-level block request valid |
| mem_req_ready_i | input | 1 | Next level accepts the request |
| mem_req_addr_o | output | 14 | Requested block address |
| mem_rsp_valid_i | input | 1 | Next-level line returned |
| mem_rsp_data_i | input | 128 | Returned line, word 0 in the low bits |
| hit_cnt_o | output | 16 | Array hit count |
| vhit_cnt_o | output | 16 | Side-store hit count |
| miss_cnt_o | output | 16 | Next-level request count |

## Verification
The assertions check properties that hold on every cycle:
- the request handshake holds its address until accepted,
- the block accepts only one read at a time,
- each read moves exactly one counter,
- an array hit is answered in the following cycle,
- the side store is written with a valid line only when the displaced array line was valid.

Some behaviours show only in the bench's scenarios:
- the swap on a side-store hit,
- replacement order in the side store,
- the ping-pong stream running free of next-level requests,
- the absence of insertion on fills into empty sets.

The bench shows each of these through hit and miss outcomes and the returned data.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_VSRCH,
    ST_MREQ,
    ST_MWAIT
  } vc_state_e;
endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
  parameter int SETS  = 16,
  parameter int TAGW  = 10,
  parameter int LINEW = 128,
  localparam int IDXW = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDXW-1:0]  idx_i,
  output logic             rd_valid_o,
  output logic [TAGW-1:0]  rd_tag_o,
  output logic [LINEW-1:0] rd_line_o,
  input  logic             wr_en_i,
  input  logic [TAGW-1:0]  wr_tag_i,
  input  logic [LINEW-1:0] wr_line_i
);
  logic             valid_q [SETS];
  logic [TAGW-1:0]  tag_q   [SETS];
  logic [LINEW-1:0] line_q  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[g] <= 1'b0;
      else if (wr_en_i && idx_i == IDXW'(g)) valid_q[g] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (wr_en_i && idx_i == IDXW'(g)) begin
        tag_q[g]  <= wr_tag_i;
        line_q[g] <= wr_line_i;
      end
    end
  end

  assign rd_valid_o = valid_q[idx_i];
  assign rd_tag_o   = tag_q[idx_i];
  assign rd_line_o  = line_q[idx_i];
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int NV    = 4,
  parameter int BAW   = 14,
  parameter int LINEW = 128,
  localparam int SW   = $clog2(NV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BAW-1:0]   lk_addr_i,
  output logic             hit_o,
  output logic [SW-1:0]    hit_slot_o,
  output logic [LINEW-1:0] hit_line_o,
  output logic [SW-1:0]    alloc_slot_o,
  input  logic             wr_en_i,
  input  logic [SW-1:0]    wr_slot_i,
  input  logic             wr_valid_i,
  input  logic [BAW-1:0]   wr_addr_i,
  input  logic [LINEW-1:0] wr_line_i
);
  logic             valid_q [NV];
  logic [BAW-1:0]   addr_q  [NV];
  logic [LINEW-1:0] line_q  [NV];
  logic [SW-1:0]    age_q   [NV];  // permutation of 0..NV-1, 0 = most recent
  logic [NV-1:0]    match;
  logic             touch;

  assign touch = wr_en_i && wr_valid_i;

  for (genvar g = 0; g < NV; g++) begin : g_ent
    assign match[g] = valid_q[g] && (addr_q[g] == lk_addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        age_q[g]   <= SW'(g);
      end else begin
        if (wr_en_i && wr_slot_i == SW'(g)) valid_q[g] <= wr_valid_i;
        if (touch) begin
          if (wr_slot_i == SW'(g))                 age_q[g] <= '0;
          else if (age_q[g] < age_q[wr_slot_i])   age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (touch && wr_slot_i == SW'(g)) begin
        addr_q[g] <= wr_addr_i;
        line_q[g] <= wr_line_i;
      end
    end
  end

  always_comb begin
    hit_slot_o = '0;
    for (int i = 0; i < NV; i++) if (match[i]) hit_slot_o = SW'(i);
  end
  assign hit_o      = |match;
  assign hit_line_o = line_q[hit_slot_o];

  // empty slot first (lowest index), else the oldest entry
  always_comb begin
    alloc_slot_o = '0;
    for (int i = 0; i < NV; i++) if (age_q[i] == SW'(NV - 1)) alloc_slot_o = SW'(i);
    for (int i = NV - 1; i >= 0; i--) if (!valid_q[i]) alloc_slot_o = SW'(i);
  end
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int WW   = 32,
  parameter int WPL  = 4,
  parameter int SETS = 16,
  parameter int NV   = 4,
  parameter int CW   = 16,
  localparam int OFFW  = $clog2(WPL),
  localparam int IDXW  = $clog2(SETS),
  localparam int TAGW  = AW - OFFW - IDXW,
  localparam int BAW   = AW - OFFW,
  localparam int LINEW = WW * WPL,
  localparam int SW    = $clog2(NV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  output logic             rsp_valid_o,
  output logic [WW-1:0]    rsp_data_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [BAW-1:0]   mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [LINEW-1:0] mem_rsp_data_i,
  output logic [CW-1:0]    hit_cnt_o,
  output logic [CW-1:0]    vhit_cnt_o,
  output logic [CW-1:0]    miss_cnt_o,
  output logic [IDXW-1:0]  dm_idx_o,
  input  logic             dm_rd_valid_i,
  input  logic [TAGW-1:0]  dm_rd_tag_i,
  input  logic [LINEW-1:0] dm_rd_line_i,
  output logic             dm_wr_en_o,
  output logic [TAGW-1:0]  dm_wr_tag_o,
  output logic [LINEW-1:0] dm_wr_line_o,
  output logic [BAW-1:0]   vb_lk_addr_o,
  input  logic             vb_hit_i,
  input  logic [SW-1:0]    vb_hit_slot_i,
  input  logic [LINEW-1:0] vb_hit_line_i,
  input  logic [SW-1:0]    vb_alloc_i,
  output logic             vb_wr_en_o,
  output logic [SW-1:0]    vb_wr_slot_o,
  output logic             vb_wr_valid_o,
  output logic [BAW-1:0]   vb_wr_addr_o,
  output logic [LINEW-1:0] vb_wr_line_o
);
  vc_state_e        state_q, state_d;
  logic [AW-1:0]    addr_q;
  logic [OFFW-1:0]  off;
  logic [TAGW-1:0]  tag;
  logic             main_hit;
  logic [LINEW-1:0] src_line;
  logic             rsp_set;
  logic             inc_hit, inc_vhit, inc_miss;

  assign off      = addr_q[OFFW-1:0];
  assign dm_idx_o = addr_q[OFFW+IDXW-1:OFFW];
  assign tag      = addr_q[AW-1:OFFW+IDXW];
  assign main_hit = dm_rd_valid_i && (dm_rd_tag_i == tag);

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_req_addr_o  = addr_q[AW-1:OFFW];
  assign vb_lk_addr_o    = addr_q[AW-1:OFFW];
  assign dm_wr_tag_o     = tag;
  assign vb_wr_addr_o    = {dm_rd_tag_i, dm_idx_o};
  assign vb_wr_line_o    = dm_rd_line_i;

  always_comb begin
    state_d       = state_q;
    dm_wr_en_o    = 1'b0;
    dm_wr_line_o  = mem_rsp_data_i;
    vb_wr_en_o    = 1'b0;
    vb_wr_slot_o  = vb_alloc_i;
    vb_wr_valid_o = 1'b0;
    src_line      = dm_rd_line_i;
    rsp_set       = 1'b0;
    inc_hit       = 1'b0;
    inc_vhit      = 1'b0;
    inc_miss      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (main_hit) begin
          rsp_set = 1'b1;
          inc_hit = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_VSRCH;
        end
      end
      ST_VSRCH: begin
        if (vb_hit_i) begin
          // swap: side line into the array, array line into the freed slot
          dm_wr_en_o    = 1'b1;
          dm_wr_line_o  = vb_hit_line_i;
          vb_wr_en_o    = 1'b1;
          vb_wr_slot_o  = vb_hit_slot_i;
          vb_wr_valid_o = dm_rd_valid_i;
          src_line      = vb_hit_line_i;
          rsp_set       = 1'b1;
          inc_vhit      = 1'b1;
          state_d       = ST_IDLE;
        end else begin
          inc_miss = 1'b1;
          state_d  = ST_MREQ;
        end
      end
      ST_MREQ: if (mem_req_ready_i) state_d = ST_MWAIT;
      ST_MWAIT: begin
        if (mem_rsp_valid_i) begin
          dm_wr_en_o    = 1'b1;
          vb_wr_en_o    = dm_rd_valid_i;
          vb_wr_valid_o = dm_rd_valid_i;
          src_line      = mem_rsp_data_i;
          rsp_set       = 1'b1;
          state_d       = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      hit_cnt_o   <= '0;
      vhit_cnt_o  <= '0;
      miss_cnt_o  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_set;
      if (state_q == ST_IDLE && req_valid_i) addr_q <= req_addr_i;
      if (rsp_set) rsp_data_o <= src_line[32'(off)*WW +: WW];
      if (inc_hit)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (inc_vhit) vhit_cnt_o <= vhit_cnt_o + 1'b1;
      if (inc_miss) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int AW   = 16,
  parameter int WW   = 32,
  parameter int WPL  = 4,
  parameter int SETS = 16,
  parameter int NV   = 4,
  parameter int CW   = 16,
  localparam int OFFW  = $clog2(WPL),
  localparam int IDXW  = $clog2(SETS),
  localparam int TAGW  = AW - OFFW - IDXW,
  localparam int BAW   = AW - OFFW,
  localparam int LINEW = WW * WPL,
  localparam int SW    = $clog2(NV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_addr_i,
  output logic             rsp_valid_o,
  output logic [WW-1:0]    rsp_data_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [BAW-1:0]   mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [LINEW-1:0] mem_rsp_data_i,
  output logic [CW-1:0]    hit_cnt_o,
  output logic [CW-1:0]    vhit_cnt_o,
  output logic [CW-1:0]    miss_cnt_o
);
  logic [IDXW-1:0]  dm_idx;
  logic             dm_rd_valid;
  logic [TAGW-1:0]  dm_rd_tag;
  logic [LINEW-1:0] dm_rd_line;
  logic             dm_wr_en;
  logic [TAGW-1:0]  dm_wr_tag;
  logic [LINEW-1:0] dm_wr_line;
  logic [BAW-1:0]   vb_lk_addr;
  logic             vb_hit;
  logic [SW-1:0]    vb_hit_slot;
  logic [LINEW-1:0] vb_hit_line;
  logic [SW-1:0]    vb_alloc;
  logic             vb_wr_en;
  logic [SW-1:0]    vb_wr_slot;
  logic             vb_wr_valid;
  logic [BAW-1:0]   vb_wr_addr;
  logic [LINEW-1:0] vb_wr_line;

  vc_dm_array #(.SETS(SETS), .TAGW(TAGW), .LINEW(LINEW)) u_dm (
    .clk_i, .rst_ni,
    .idx_i(dm_idx), .rd_valid_o(dm_rd_valid), .rd_tag_o(dm_rd_tag), .rd_line_o(dm_rd_line),
    .wr_en_i(dm_wr_en), .wr_tag_i(dm_wr_tag), .wr_line_i(dm_wr_line)
  );

  vc_victim_buf #(.NV(NV), .BAW(BAW), .LINEW(LINEW)) u_vb (
    .clk_i, .rst_ni,
    .lk_addr_i(vb_lk_addr), .hit_o(vb_hit), .hit_slot_o(vb_hit_slot), .hit_line_o(vb_hit_line),
    .alloc_slot_o(vb_alloc),
    .wr_en_i(vb_wr_en), .wr_slot_i(vb_wr_slot), .wr_valid_i(vb_wr_valid),
    .wr_addr_i(vb_wr_addr), .wr_line_i(vb_wr_line)
  );

  vc_ctrl #(.AW(AW), .WW(WW), .WPL(WPL), .SETS(SETS), .NV(NV), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_addr_i, .rsp_valid_o, .rsp_data_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o, .mem_rsp_valid_i, .mem_rsp_data_i,
    .hit_cnt_o, .vhit_cnt_o, .miss_cnt_o,
    .dm_idx_o(dm_idx), .dm_rd_valid_i(dm_rd_valid), .dm_rd_tag_i(dm_rd_tag), .dm_rd_line_i(dm_rd_line),
    .dm_wr_en_o(dm_wr_en), .dm_wr_tag_o(dm_wr_tag), .dm_wr_line_o(dm_wr_line),
    .vb_lk_addr_o(vb_lk_addr), .vb_hit_i(vb_hit), .vb_hit_slot_i(vb_hit_slot),
    .vb_hit_line_i(vb_hit_line), .vb_alloc_i(vb_alloc),
    .vb_wr_en_o(vb_wr_en), .vb_wr_slot_o(vb_wr_slot), .vb_wr_valid_o(vb_wr_valid),
    .vb_wr_addr_o(vb_wr_addr), .vb_wr_line_o(vb_wr_line)
  );
endmodule

// File: rtl/vcache_chk.sv
module vcache_chk #(
  parameter int BAW = 14,
  parameter int CW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           rsp_valid_o,
  input logic           mem_req_valid_o,
  input logic           mem_req_ready_i,
  input logic [BAW-1:0] mem_req_addr_o,
  input logic [CW-1:0]  hit_cnt_o,
  input logic [CW-1:0]  vhit_cnt_o,
  input logic [CW-1:0]  miss_cnt_o,
  input logic           old_line_valid,
  input logic           vb_wr_en,
  input logic           vb_wr_valid
);
  a_r11_one_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r5_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

  a_r9_one_counter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hit_cnt_o != $past(hit_cnt_o), vhit_cnt_o != $past(vhit_cnt_o),
                miss_cnt_o != $past(miss_cnt_o)}) <= 1);

  a_r2_hit_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_o != $past(hit_cnt_o) |-> rsp_valid_o);

  a_r6_evicted_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vb_wr_en && vb_wr_valid |-> old_line_valid);
endmodule

bind vcache_top vcache_chk #(.BAW(BAW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
  .hit_cnt_o(hit_cnt_o), .vhit_cnt_o(vhit_cnt_o), .miss_cnt_o(miss_cnt_o),
  .old_line_valid(dm_rd_valid), .vb_wr_en(vb_wr_en), .vb_wr_valid(vb_wr_valid)
);

// File: tb/vcache_top_test.sv
`timescale 1ns/1ps
module vcache_top_test;
  localparam int MEM_LAT = 3;
  localparam int K_HIT = 0, K_VHIT = 1, K_MISS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [15:0]  req_addr = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [13:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic [15:0]  hit_cnt, vhit_cnt, miss_cnt;

  int checks = 0;
  int errors = 0;
  int mem_reqs = 0;
  logic [13:0] last_mem_addr = '0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  vcache_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data),
    .hit_cnt_o(hit_cnt), .vhit_cnt_o(vhit_cnt), .miss_cnt_o(miss_cnt)
  );

  function automatic logic [31:0] word_of(logic [15:0] a);
    return {a, ~a ^ 16'h3c5a};
  endfunction

  function automatic logic [127:0] line_of(logic [13:0] blk);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_of({blk, 2'(w)});
    return l;
  endfunction

  function automatic logic [15:0] mk(int tag, int idx, int off);
    return {10'(tag), 4'(idx), 2'(off)};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next-level model: ready after one idle cycle, line after MEM_LAT cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && rst_n) begin
        @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_reqs++;
        last_mem_addr = mem_req_addr;
        repeat (MEM_LAT) @(negedge clk);
        mem_rsp_data  = line_of(last_mem_addr);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // monitor: compare each response with the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected response", rsp_data, 0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(logic [15:0] a, int kind, string req);
    int h0, v0, m0, r0;
    h0 = hit_cnt; v0 = vhit_cnt; m0 = miss_cnt; r0 = mem_reqs;
    exp_q.push_back(word_of(a));
    tag_q.push_back({req, " data"});
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(int'(hit_cnt)  - h0 == (kind == K_HIT  ? 1 : 0), {req, " R9 hit count"},  hit_cnt - h0,  kind == K_HIT);
    check(int'(vhit_cnt) - v0 == (kind == K_VHIT ? 1 : 0), {req, " R3 vhit count"}, vhit_cnt - v0, kind == K_VHIT);
    check(int'(miss_cnt) - m0 == (kind == K_MISS ? 1 : 0), {req, " R5 miss count"}, miss_cnt - m0, kind == K_MISS);
    check(mem_reqs - r0 == (kind == K_MISS ? 1 : 0), {req, " R5 next-level requests"}, mem_reqs - r0, kind == K_MISS);
    if (kind == K_MISS)
      check(last_mem_addr == a[15:2], {req, " R5 block address"}, last_mem_addr, a[15:2]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 quiet outputs", {rsp_valid, mem_req_valid}, 0);
    check(hit_cnt == 0 && vhit_cnt == 0 && miss_cnt == 0, "R1 counters", {hit_cnt, vhit_cnt, miss_cnt}, 0);

    // R2/R3/R4/R5 basic swap, then R8 ping-pong
    do_read(mk(1, 3, 1), K_MISS, "R5 cold A");
    do_read(mk(1, 3, 2), K_HIT,  "R2 A word2");
    do_read(mk(2, 3, 0), K_MISS, "R5 conflicting B");
    do_read(mk(1, 3, 3), K_VHIT, "R3 A from side store");
    do_read(mk(2, 3, 1), K_VHIT, "R4 B displaced by swap");
    do_read(mk(2, 3, 2), K_HIT,  "R4 B now in array");
    begin
      int m0;
      m0 = mem_reqs;
      for (int i = 0; i < 8; i++)
        do_read((i % 2 == 0) ? mk(1, 3, i % 4) : mk(2, 3, i % 4), K_VHIT, "R8 ping-pong");
      check(mem_reqs == m0, "R8 no next-level traffic", mem_reqs - m0, 0);
    end
    check(int'(hit_cnt) + int'(vhit_cnt) + int'(miss_cnt) == 14, "R9 counter total",
          hit_cnt + vhit_cnt + miss_cnt, 14);

    // R6: fills of empty sets must not consume side-store slots
    do_reset();
    do_read(mk(1, 2, 0), K_MISS, "R6 X");
    do_read(mk(2, 2, 0), K_MISS, "R6 Y evicts X");
    do_read(mk(1, 7, 0), K_MISS, "R6 empty set 7");
    do_read(mk(1, 8, 0), K_MISS, "R6 empty set 8");
    do_read(mk(1, 9, 0), K_MISS, "R6 empty set 9");
    do_read(mk(2, 7, 0), K_MISS, "R6 evict into side store");
    do_read(mk(1, 2, 1), K_VHIT, "R6 X still held");

    // R7: empty slots first, then oldest replaced
    do_reset();
    for (int t = 0; t < 6; t++) do_read(mk(t + 1, 0, 0), K_MISS, "R7 fill chain");
    do_read(mk(1, 0, 1), K_MISS, "R7 oldest dropped");
    do_read(mk(3, 0, 2), K_VHIT, "R7 newer kept");
    do_read(mk(2, 0, 3), K_MISS, "R7 next oldest dropped");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule